// File: doc/BRIEF.md
# Per-Core Interprocessor Interrupt Register File

This block sits beside one processor core and gathers interrupt requests sent to that core by other cores, together with a small bank of 32-bit message words. Software and the delivery fabric reach it through a plain 32-bit register port with a one-cycle write strobe and a combinational read path. A single level interrupt line goes to the core.

Requests are posted by writing a bit pattern to the set port. The handler retires them by writing the same bits to the clear port. An enable mask selects which pending bits may raise the line. The line is kept by a two-state machine, `IRQ_LOW` and `IRQ_HIGH`. It moves only on set or clear writes.

- The transition `RAISE` (`IRQ_LOW` to `IRQ_HIGH`) fires on a set write when the updated pending vector is nonzero and has a bit in common with the enable mask.
- The transition `LOWER` (`IRQ_HIGH` to `IRQ_LOW`) fires on a clear write when the updated pending vector is zero and the enable mask is nonzero.
- Every other access keeps the current state. This includes writes to the enable mask.

Only the low eight address bits are decoded. Accesses that match no register, and writes to the read-only pending vector, produce a one-cycle error pulse.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset the pending vector, enable mask and all eight message words read zero, and `irq` and `err_pulse` are low.
- R2: Only `addr[7:0]` is decoded. Any value on the upper address bits selects the same register as the low byte alone.
- R3: The enable mask is at offset 0x04 and reads back the last value written. Writing it never changes `irq`.
- R4: A write to the set port at offset 0x08 ORs `wdata` into the pending vector. Reads of the set port and of the clear port at offset 0x0C always return zero.
- R5: A set write drives `irq` high in the following cycle when the updated pending vector is nonzero and its AND with the enable mask is nonzero. Otherwise the set write leaves `irq` unchanged.
- R6: A write to the clear port clears every pending bit that is 1 in `wdata` and leaves the other bits alone.
- R7: A clear write drives `irq` low in the following cycle only when the updated pending vector is zero and the enable mask is nonzero. Otherwise the clear write leaves `irq` unchanged.
- R8: The pending vector is at offset 0x00 and cannot be written. A write there leaves it unchanged and raises `err_pulse` for the cycle after the write.
- R9: Eight 32-bit message words occupy offsets 0x20 to 0x3F. The word index is (offset - 0x20) >> 2, so the two low offset bits are ignored. Each word reads back what was last written to it.
- R10: An offset matching no register reads as zero and a write to it changes no state. Either access raises `err_pulse` for the cycle after. Offsets 0x01 to 0x03, 0x05 to 0x07, 0x09 to 0x0B and 0x0D to 0x1F count as unmapped.
- R11: `irq` changes only in the cycle after a set or clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, used for the error pulse |
| addr | input | ADDR_W (12) | Register address; bits above 7 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt line to the core |
| err_pulse | output | 1 | One-cycle flag for unmapped or illegal access |

## Verification
Assertions check on every cycle the properties that hold without context:
- `irq` rises only after a set write (R5, R11) and falls only after a clear write (R7, R11);
- a write to the pending vector leaves it unchanged (R8);
- an enable write leaves `irq` unchanged (R3);
- a set write leaves all written bits pending (R4);
- a message-word write is stored (R9);
- a bad access is followed by the error pulse (R10).

Only the bench scenarios can show the asymmetric cases. These include a clear with a zero enable mask that leaves the line high, a set whose bits miss the mask, and register aliasing across upper address bits. The bench also sweeps all 256 offsets, so it confirms that unmapped offsets and the set and clear ports read zero.

// File: rtl/ipi_core_pkg.sv
package ipi_core_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [2:0] {
        SEL_PEND,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBOX,
        SEL_NONE
    } ipi_sel_e;

    typedef enum logic {
        IRQ_LOW,
        IRQ_HIGH
    } irq_state_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_core_pkg::*;
#(
    parameter int unsigned MBOX_N    = 8,
    parameter logic [7:0]  MBOX_BASE = 8'h20,
    localparam int unsigned IDX_W    = (MBOX_N > 1) ? $clog2(MBOX_N) : 1
) (
    input  logic [7:0]       offset,
    output ipi_sel_e         sel,
    output logic [IDX_W-1:0] mbox_idx
);
    localparam int unsigned MBOX_END = int'(MBOX_BASE) + 4 * MBOX_N;

    logic [7:0] rel;

    always_comb begin
        rel      = offset - MBOX_BASE;
        mbox_idx = rel[IDX_W+1:2];
        if (offset == 8'h00)
            sel = SEL_PEND;
        else if (offset == 8'h04)
            sel = SEL_MASK;
        else if (offset == 8'h08)
            sel = SEL_SET;
        else if (offset == 8'h0C)
            sel = SEL_CLR;
        else if (int'(offset) >= int'(MBOX_BASE) && int'(offset) < MBOX_END)
            sel = SEL_MBOX;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/ipi_mbox_bank.sv
module ipi_mbox_bank
    import ipi_core_pkg::*;
#(
    parameter int unsigned MBOX_N = 8,
    localparam int unsigned IDX_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] words [MBOX_N];

    for (genvar g = 0; g < MBOX_N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && idx == IDX_W'(g))
                words[g] <= wdata;
        end
    end

    assign rword = words[idx];

    // R9
    mbox_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words[$past(idx)] == $past(wdata));
endmodule

// File: rtl/ipi_irq_fsm.sv
module ipi_irq_fsm
    import ipi_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] pend_nxt,
    input  logic [DATA_W-1:0] mask,
    output logic              irq
);
    irq_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= IRQ_LOW;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            IRQ_LOW:
                if (set_wr && pend_nxt != '0 && (pend_nxt & mask) != '0)
                    state_nxt = IRQ_HIGH;
            IRQ_HIGH:
                if (clr_wr && pend_nxt == '0 && mask != '0)
                    state_nxt = IRQ_LOW;
            default: state_nxt = IRQ_LOW;
        endcase
    end

    always_comb irq = (state == IRQ_HIGH);

    // R5
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_wr));
    // R7
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_wr));
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(irq));
    // R3
    mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> $stable(irq));
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_core_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MBOX_N    = 8,
    parameter logic [7:0]  MBOX_BASE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              err_pulse
);
    localparam int unsigned IDX_W = (MBOX_N > 1) ? $clog2(MBOX_N) : 1;

    ipi_sel_e          sel;
    logic [IDX_W-1:0]  mbox_idx;
    logic [DATA_W-1:0] pend, pend_nxt, mask, mbox_word;
    logic              set_wr, clr_wr, mask_wr, bad_acc;
    logic              unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:8];

    ipi_addr_decode #(.MBOX_N(MBOX_N), .MBOX_BASE(MBOX_BASE)) u_dec (
        .offset  (addr[7:0]),
        .sel     (sel),
        .mbox_idx(mbox_idx)
    );

    assign set_wr  = wr_en && sel == SEL_SET;
    assign clr_wr  = wr_en && sel == SEL_CLR;
    assign mask_wr = wr_en && sel == SEL_MASK;
    assign bad_acc = (wr_en && (sel == SEL_NONE || sel == SEL_PEND))
                   || (rd_en && sel == SEL_NONE);

    always_comb begin
        pend_nxt = pend;
        if (set_wr)
            pend_nxt = pend | wdata;
        else if (clr_wr)
            pend_nxt = pend & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            mask      <= '0;
            err_pulse <= 1'b0;
        end else begin
            pend      <= pend_nxt;
            err_pulse <= bad_acc;
            if (mask_wr)
                mask <= wdata;
        end
    end

    ipi_mbox_bank #(.MBOX_N(MBOX_N)) u_mbox (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en && sel == SEL_MBOX),
        .idx  (mbox_idx),
        .wdata(wdata),
        .rword(mbox_word)
    );

    ipi_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr),
        .mask_wr (mask_wr),
        .pend_nxt(pend_nxt),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND: rdata = pend;
            SEL_MASK: rdata = mask;
            SEL_MBOX: rdata = mbox_word;
            default:  rdata = '0;
        endcase
    end

    // R8
    pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PEND) |=> $stable(pend));
    // R4
    set_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (pend & $past(wdata)) == $past(wdata));
    // R10
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && sel == SEL_NONE) |=> err_pulse);
endmodule

// File: tb/ipi_core_regs_tb_top.sv
`timescale 1ns/1ps
module ipi_core_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, err_pulse;

    int n_run = 0, n_fail = 0;
    logic done = 1'b0;

    logic [31:0] m_pend = '0, m_mask = '0;
    logic [31:0] m_box [8];
    logic        m_irq = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #2 clk = ~clk;

    ipi_core_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .err_pulse(err_pulse)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_bad(input logic [7:0] o, input logic wr);
        if (o == 8'h00) return wr;
        if (o == 8'h04 || o == 8'h08 || o == 8'h0C) return 1'b0;
        if (o >= 8'h20 && o <= 8'h3F) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] o);
        if (o == 8'h00) return m_pend;
        if (o == 8'h04) return m_mask;
        if (o >= 8'h20 && o <= 8'h3F) return m_box[(o - 8'h20) >> 2];
        return 32'h0;
    endfunction

    // model update, R4 R5 R6 R7 R8 R9 R10
    task automatic model_write(input logic [7:0] o, input logic [31:0] d);
        if (o == 8'h04) m_mask = d;
        else if (o == 8'h08) begin
            m_pend = m_pend | d;
            if (m_pend != 0 && (m_pend & m_mask) != 0) m_irq = 1'b1;
        end else if (o == 8'h0C) begin
            m_pend = m_pend & ~d;
            if (m_pend == 0 && m_mask != 0) m_irq = 1'b0;
        end else if (o >= 8'h20 && o <= 8'h3F) m_box[(o - 8'h20) >> 2] = d;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(a[7:0], d);
        check({req, " R10/R8 err"}, {31'b0, err_pulse}, {31'b0, is_bad(a[7:0], 1'b1)});
        check({req, " R11 irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        logic [31:0] got;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 got = rdata;
        check(req, got, exp_read(a[7:0]));
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        check({req, " R10 err"}, {31'b0, err_pulse}, {31'b0, is_bad(a[7:0], 1'b0)});
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) m_box[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 err", {31'b0, err_pulse}, 32'h0);
        for (int o = 0; o < 64; o += 4) do_read(12'(o), "R1 reset read");

        // R10 R4 R8: full read sweep of all offsets
        for (int o = 0; o < 256; o++) do_read({4'(o * 3), 8'(o)}, "R10 read sweep");

        // R9 mailbox fill including unaligned offsets, R2 aliasing
        for (int o = 32'h20; o < 32'h40; o++)
            do_write({4'(o), 8'(o)}, {8'(o), 8'(~o), 8'(o * 5), 8'(o + 1)}, "R9 mbox write");
        for (int o = 32'h20; o < 32'h40; o++) do_read({4'hF, 8'(o)}, "R9 R2 mbox read");

        // R10 unmapped writes leave state alone
        for (int o = 0; o < 256; o++)
            if (is_bad(8'(o), 1'b1)) do_write({4'h5, 8'(o)}, 32'hFFFF_FFFF, "R10 R8 bad write");
        for (int o = 0; o < 64; o++) do_read(12'(o), "R10 state intact");

        // R5: set with bits outside mask keeps irq low
        do_write(12'h004, 32'h0000_00F0, "R3 mask");
        do_write(12'h008, 32'h0000_0003, "R5 set miss");
        check("R5 irq low", {31'b0, irq}, 32'h0);
        do_write(12'h708, 32'h0000_0010, "R5 R2 set hit");
        check("R5 irq high", {31'b0, irq}, 32'h1);
        // R3 mask write does not change irq
        do_write(12'h004, 32'h0, "R3 mask zero");
        check("R3 irq kept", {31'b0, irq}, 32'h1);
        // R7 clear to zero with zero mask keeps irq
        do_write(12'h00C, 32'hFFFF_FFFF, "R7 clr maskzero");
        check("R7 irq stays", {31'b0, irq}, 32'h1);
        do_read(12'h000, "R6 pend zero");
        // R7 partial clear keeps irq, full clear lowers
        do_write(12'h004, 32'h1, "R3 mask");
        do_write(12'h008, 32'h0000_0005, "R4 set");
        do_write(12'h00C, 32'h0000_0001, "R6 partial clr");
        check("R7 irq partial", {31'b0, irq}, 32'h1);
        do_read(12'h000, "R6 pend");
        do_write(12'h00C, 32'h0000_0004, "R7 full clr");
        check("R7 irq low", {31'b0, irq}, 32'h0);

        // random set/clear/mask sequence
        for (int k = 0; k < 400; k++) begin
            logic [1:0] op;
            lfsr = step(lfsr); op = lfsr[1:0];
            lfsr = step(lfsr);
            case (op)
                2'd0: do_write(12'h004, lfsr & 32'h0000_0F0F, "R3 rnd mask");
                2'd1: do_write(12'h008, lfsr & 32'h0000_FFFF & {16'h0, lfsr[31:16]}, "R5 rnd set");
                2'd2: do_write(12'h00C, lfsr | (lfsr >> 3), "R7 rnd clr");
                default: do_read({lfsr[11:8], 6'h0, lfsr[3:2]} , "R4 rnd read");
            endcase
        end
        do_read(12'h000, "R4 final pend");
        do_read(12'h004, "R3 final mask");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule